// File: doc/BRIEF.md
# Dual-Enable Gated Binary Counter

This block is a binary up-counter whose advance on each clock edge is governed by two synchronous enable inputs combined through an exclusive-OR. When the two enables agree (both low or both high) the counter advances by one on the edge. When they disagree it holds its value on that edge. A separate start input forces counting regardless of the enables, and an asynchronous active-high reset clears the count at any time.

The enable pair is sampled on the same clock edge that it governs. An enable change that coincides with an edge therefore takes effect on that edge and is never one cycle late. The count is presented both true and complemented, so that a downstream consumer can pick either polarity. It serves as a programmable divider or a gated event counter: the clock output of bit k toggles at 1/2^(k+1) of the enabled edge rate.

Top module: `dual_enable_counter`

## Requirements
- R1: While `rst` is high the count is zero (`q` = 0, `q_n` = all ones), taking effect without waiting for a clock edge and overriding `start` and both enables.
- R2: With `rst` low, `start` low and both `en_a` and `en_b` low at a rising edge, `q` becomes its previous value plus one.
- R3: With `rst` low, `start` low and both `en_a` and `en_b` high at a rising edge, `q` becomes its previous value plus one.
- R4: With `rst` low, `start` low and exactly one of `en_a`/`en_b` high at a rising edge, `q` keeps its previous value across that edge; the hold applies from the very edge on which the lone enable is sampled.
- R5: With `rst` low and `start` high at a rising edge, `q` becomes its previous value plus one whatever the state of `en_a` and `en_b`.
- R6: An advancing edge with `q` = all ones (8'hFF at the default width) makes `q` all zeros; there is no saturation.
- R7: `q_n` is at all times the bitwise complement of `q`, with bit 0 of each the least significant bit.
- R8: After one or more held edges, the next advancing edge continues from the held value plus one; no count is lost or gained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Asynchronous active-high master clear |
| start | input | 1 | Forces counting on, overriding the enable pair |
| en_a | input | 1 | First synchronous enable |
| en_b | input | 1 | Second synchronous enable |
| q | output | WIDTH (8) | Count value, bit 0 least significant |
| q_n | output | WIDTH (8) | Bitwise complement of the count |

## Verification
The in-RTL properties take for granted that `start`, `en_a` and `en_b` are settled before each rising edge and do not move on it. They also assume that `rst` is never released on the same instant as a rising edge, so that the value sampled at each edge is unambiguous. The bench changes every input only on the falling clock edge, so that each one is stable for half a period around the rising edge. It asserts and releases the reset mid-phase, including once with `start` high while a count is in progress.

// File: rtl/dual_enable_counter_pkg.sv
package dual_enable_counter_pkg;
  localparam int unsigned DEFAULT_WIDTH = 8;

  // Decision taken for one clock edge
  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,
    STEP_GATED   = 2'd1,
    STEP_FORCED  = 2'd2
  } step_kind_e;
endpackage

// File: rtl/dec_enable_gate.sv
module dec_enable_gate
  import dual_enable_counter_pkg::*;
(
  input  logic       start,
  input  logic       en_a,
  input  logic       en_b,
  output step_kind_e step,
  output logic       advance
);
  logic disagree;

  always_comb begin
    disagree = en_a ^ en_b;
    if (start)          step = STEP_FORCED;
    else if (!disagree) step = STEP_GATED;
    else                step = STEP_HOLD;
    advance = (step != STEP_HOLD);
  end
endmodule

// File: rtl/dec_count_core.sv
module dec_count_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             start,
  input  logic             en_a,
  input  logic             en_b,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          count <= '0;
    else if (advance) count <= count + ONE;
  end

  // R1: clear visible whenever reset is sampled high
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |-> count == '0);

  // R2/R3: agreeing enables advance the count
  assert_agree_counts_R2: assert property (@(posedge clk) disable iff (rst)
    (!start && (en_a == en_b)) |=> count == $past(count) + ONE);

  // R4: a lone enable holds the count on that very edge
  assert_lone_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!start && (en_a != en_b)) |=> $stable(count));

  // R5: start overrides the enable pair
  assert_start_counts_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> count == $past(count) + ONE);

  // R6: wrap from all ones to zero
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (count == ALL_ONES && (start || en_a == en_b)) |=> count == '0);
endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q[i]   = count[i];
    assign q_n[i] = ~count[i];
  end
endmodule

// File: rtl/dual_enable_counter.sv
module dual_enable_counter
  import dual_enable_counter_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             en_a,
  input  logic             en_b,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);
  step_kind_e       step;
  logic             advance;
  logic [WIDTH-1:0] count;

  dec_enable_gate u_gate (
    .start   (start),
    .en_a    (en_a),
    .en_b    (en_b),
    .step    (step),
    .advance (advance)
  );

  dec_count_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .start   (start),
    .en_a    (en_a),
    .en_b    (en_b),
    .count   (count)
  );

  dec_out_stage #(.WIDTH(WIDTH)) u_out (
    .count (count),
    .q     (q),
    .q_n   (q_n)
  );

  // The gate decision kind is one-hot or hold
  assert_step_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (start |-> step == STEP_FORCED));
endmodule

// File: tb/dual_enable_counter_tb.sv
module dual_enable_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       en_a = 1'b0;
  logic       en_b = 1'b0;
  logic [7:0] q;
  logic [7:0] q_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int    model = 0;
  string tag = "R1";
  bit    was_held = 1'b0;

  always #2 clk = ~clk;

  dual_enable_counter u_dut (
    .clk(clk), .rst(rst), .start(start), .en_a(en_a), .en_b(en_b),
    .q(q), .q_n(q_n)
  );

  // Behavioural reference: decides each edge from the requirements
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      model = 0;
      tag = "R1";
      was_held = 1'b0;
    end else if (start) begin
      tag = (model == 255) ? "R6" : (was_held ? "R8" : "R5");
      model = (model + 1) % 256;
      was_held = 1'b0;
    end else if (en_a != en_b) begin
      tag = "R4";
      was_held = 1'b1;
    end else begin
      if (model == 255)      tag = "R6";
      else if (was_held)     tag = "R8";
      else if (en_a)         tag = "R3";
      else                   tag = "R2";
      model = (model + 1) % 256;
      was_held = 1'b0;
    end
  end

  task automatic check_now(string req);
    total++;
    if (q !== model[7:0]) begin
      bad++;
      $display("FAIL %s q actual=%h expected=%h", req, q, model[7:0]);
    end
    total++;
    if (q_n !== ~model[7:0]) begin
      bad++;
      $display("FAIL R7 q_n actual=%h expected=%h", q_n, ~model[7:0]);
    end
  endtask

  task automatic step(input bit a, input bit b, input bit s);
    @(negedge clk);
    check_now(tag);
    en_a = a; en_b = b; start = s;
  endtask

  initial begin
    #1;
    check_now("R1");
    @(negedge clk); @(negedge clk);
    check_now("R1");
    #1 rst = 1'b0;
    for (int i = 0; i < 10; i++) step(0, 0, 0);   // R2
    for (int i = 0; i < 6; i++)  step(1, 1, 0);   // R3
    for (int i = 0; i < 5; i++)  step(1, 0, 0);   // R4
    for (int i = 0; i < 5; i++)  step(0, 1, 0);   // R4
    for (int i = 0; i < 3; i++)  step(1, 1, 0);   // R8
    for (int i = 0; i < 6; i++)  step(1, 0, 1);   // R5
    for (int i = 0; i < 3; i++)  step(1, 1, 1);   // R5
    step(0, 1, 0);
    step(0, 0, 0);                                // R8 after single hold
    for (int i = 0; i < 270; i++) step(0, 0, 0);  // R6 wrap
    for (int i = 0; i < 400; i++) step($urandom_range(1), $urandom_range(1), ($urandom_range(7) == 0));
    step(0, 0, 0);
    // R1: asynchronous clear mid-cycle with start high
    start = 1'b1;
    @(posedge clk); #1;
    rst = 1'b1;
    #0.5;
    total++;
    if (q !== 8'h00 || q_n !== 8'hFF) begin
      bad++;
      $display("FAIL R1 async q actual=%h expected=00", q);
    end
    @(negedge clk);
    check_now("R1");
    @(negedge clk);
    check_now("R1");
    #1 rst = 1'b0;
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    step(0, 0, 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule